// File: doc/BRIEF.md
# DAC Channel Trigger and Data-Transfer Controller

This block is the digital front end of a single DAC channel. A 12-bit holding register is loaded by a plain write strobe. A second register is the output code that would drive the converter. Its full scale spans 4096 codes, and the analog level is the code times the reference divided by 4096. A control write sets the channel enable, the trigger enable and a 4-bit source select.

With triggering off, every holding-register write reaches the output register one cycle later. With triggering on, the output register is loaded only on a trigger event. The select value 0 stands for a software trigger bit, which hardware clears itself. Any other select value k takes hardware line k. That line is passed through a two-flop synchronizer and then an edge detector, and the synchronizer counts toward the fixed three-cycle latency. The select field is frozen while the channel is enabled.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset the output code, the software trigger bit, the channel enable, the trigger enable and the select field all read zero.
- R2: With the channel enabled and the trigger enable clear, a write of the holding register appears on `dout` one clock after the write edge. All 12 bits pass unchanged (0x000 and 0xFFF included). With the trigger enable set, such a write alone does not change `dout`.
- R3: With the channel and trigger enabled and select k (1..15), a rising edge on `hw_trig[k]` loads `dout` from the holding register on the third rising clock edge, counting the first edge that samples the line high. Before that edge `dout` keeps its old value.
- R4: A hardware line held high, or a falling edge on it, causes no transfer.
- R5: Only the selected source counts. Edges on any other hardware line cause no transfer, and `hw_trig[0]` never triggers.
- R6: With select 0 and both enables set, `sw_trig_wr` sets the software trigger bit on the write edge. On the following edge `dout` is loaded from the holding register and the bit reads 0 again.
- R7: A control write leaves the select field unchanged when the channel enable is currently 1. It updates the field when the current channel enable is 0.
- R8: With the channel enable clear, hardware edges, holding-register writes and software-trigger writes leave `dout` unchanged, and the software trigger bit stays 0.
- R9: While a hardware transfer is pending, a holding-register write is taken into account. The load that completes it uses the holding value present at the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | Holding-register write strobe |
| data_in | input | 12 | Holding-register write value |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_chan_en | input | 1 | Channel enable value to write |
| ctrl_trig_en | input | 1 | Trigger enable value to write |
| ctrl_sel | input | 4 | Source select value to write (0 = software) |
| sw_trig_wr | input | 1 | Write strobe that sets the software trigger bit |
| hw_trig | input | 16 | Asynchronous hardware trigger lines, index = select code |
| chan_en_o | output | 1 | Current channel enable |
| trig_en_o | output | 1 | Current trigger enable |
| sel_o | output | 4 | Current source select |
| sw_trig_o | output | 1 | Software trigger bit |
| dout | output | 12 | Data-output register driving the converter |

## Verification
A bad synchronizer stage or edge-detector flop shows up on `dout` one or two cycles early or late against the third-edge rule. It can also show up as an extra load while a line stays high, which is visible within three cycles of the stimulus. A lock that fails to hold appears on `sel_o` on the edge after the control write. A software bit that is not cleared stays visible on `sw_trig_o` one cycle after it was set. A corrupt holding register appears on `dout` at the next load, so each test writes a new value before it fires a trigger.

// File: rtl/dac_xfer_pkg.sv
// Shared constants for the DAC trigger and transfer controller.
// Assumes: a 12-bit converter and a 4-bit source select, where code 0 is software.
package dac_xfer_pkg;
    localparam int DATA_W      = 12;
    localparam int SEL_W       = 4;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dac_trig_sync.sv
// Selects one hardware trigger line, synchronizes it and emits a one-cycle pulse
// on each rising edge. With STAGES = 2, the pulse is high in the cycle after
// the second sampling edge.
// Assumes: sel changes only while the consumer ignores the pulse.
module dac_trig_sync #(
    parameter int SEL_W  = 4,
    parameter int STAGES = 2,
    localparam int NSRC  = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  trig_in,
    input  logic [SEL_W-1:0] sel,
    output logic             rise
);
    logic              raw;
    logic [STAGES-1:0] chain;
    logic              prev;

    // Route the selected line to the synchronizer.
    always_comb raw = trig_in[sel];

    // First synchronizer flop samples the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= raw;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_sync
            // Further synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[gi] <= 1'b0;
                else        chain[gi] <= chain[gi-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    // Rising edge of the synchronized level.
    always_comb rise = chain[STAGES-1] & ~prev;

    // R3 / R4: a pulse means the raw line was low, then high, at the right sampling edges.
    a_r3_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && $past(sel, 1) == sel && $past(sel, 2) == sel && $past(sel, 3) == sel)
        |-> ($past(raw, 2) && !$past(raw, 3)));

    // R4: no pulse on two cycles in a row.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dac_ctrl_regs.sv
// Control register: channel enable, trigger enable, source select (frozen while
// the channel is enabled) and the self-clearing software trigger bit.
// Assumes: one write strobe for control and a separate one for the software trigger.
module dac_ctrl_regs #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_chan_en,
    input  logic             wr_trig_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             sw_trig_wr,
    output logic             chan_en,
    output logic             trig_en,
    output logic [SEL_W-1:0] sel,
    output logic             sw_trig
);
    logic sw_allowed;

    // The software bit may be set only in enabled software-trigger mode.
    always_comb sw_allowed = chan_en & trig_en & (sel == '0);

    // Enable bits follow every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_en <= 1'b0;
            trig_en <= 1'b0;
        end else if (ctrl_wr) begin
            chan_en <= wr_chan_en;
            trig_en <= wr_trig_en;
        end
    end

    // The select field is written only while the channel is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sel <= '0;
        else if (ctrl_wr && !chan_en)  sel <= wr_sel;
    end

    // Software bit: set by a write, cleared on the edge at which the load happens.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_trig <= 1'b0;
        else        sw_trig <= sw_trig_wr & sw_allowed & ~sw_trig;
    end

    // R7: select is frozen while the channel enable is set.
    a_r7_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(sel));

    // R6: the software bit never stays set for two cycles.
    a_r6_sw_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> !sw_trig);

    // R8: the software bit only rises while the channel is enabled.
    a_r8_sw_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_trig) |-> $past(chan_en));
endmodule

// File: rtl/dac_xfer_path.sv
// Holding register and data-output register. Picks the load condition from
// the trigger mode: direct copy, software bit, or synchronized hardware edge.
// Assumes: hw_rise is a one-cycle pulse, sw_trig is high for one cycle.
module dac_xfer_path #(
    parameter int DATA_W = 12,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              chan_en,
    input  logic              trig_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic              sw_trig,
    input  logic              hw_rise,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] hold;
    logic              wr_seen;
    logic              load;

    // Holding register takes every write.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold <= '0;
        else if (data_wr) hold <= data_in;
    end

    // Remembers a write for the direct-copy mode on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen <= 1'b0;
        else        wr_seen <= data_wr;
    end

    // Load condition per mode, blocked while the channel is disabled.
    always_comb begin
        if (!chan_en)          load = 1'b0;
        else if (!trig_en)     load = wr_seen;
        else if (sel == '0)    load = sw_trig;
        else                   load = hw_rise;
    end

    // Output register copies the holding register on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= hold;
    end

    // R8: a disabled channel keeps its output.
    a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> $stable(dout));

    // R6: a set software bit in software mode loads the holding value on the next edge.
    a_r6_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig && chan_en && trig_en && sel == '0) |=> (dout == $past(hold)));

    // R5: in software mode a hardware pulse alone never changes the output.
    a_r5_hw_ignored_in_sw: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && sel == '0 && !sw_trig) |=> $stable(dout));
endmodule

// File: rtl/dac_xfer_ctrl.sv
// Top level of the DAC channel trigger and transfer controller. It ties the
// control register, the trigger synchronizer and the data path together.
// Assumes: synchronous active-low reset, and asynchronous hardware trigger lines.
module dac_xfer_ctrl #(
    parameter int DATA_W = dac_xfer_pkg::DATA_W,
    parameter int SEL_W  = dac_xfer_pkg::SEL_W,
    parameter int STAGES = dac_xfer_pkg::SYNC_STAGES,
    localparam int NSRC  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_chan_en,
    input  logic              ctrl_trig_en,
    input  logic [SEL_W-1:0]  ctrl_sel,
    input  logic              sw_trig_wr,
    input  logic [NSRC-1:0]   hw_trig,
    output logic              chan_en_o,
    output logic              trig_en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              sw_trig_o,
    output logic [DATA_W-1:0] dout
);
    logic hw_rise;

    dac_ctrl_regs #(.SEL_W(SEL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_chan_en (ctrl_chan_en),
        .wr_trig_en (ctrl_trig_en),
        .wr_sel     (ctrl_sel),
        .sw_trig_wr (sw_trig_wr),
        .chan_en    (chan_en_o),
        .trig_en    (trig_en_o),
        .sel        (sel_o),
        .sw_trig    (sw_trig_o)
    );

    dac_trig_sync #(.SEL_W(SEL_W), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (hw_trig),
        .sel     (sel_o),
        .rise    (hw_rise)
    );

    dac_xfer_path #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (data_wr),
        .data_in (data_in),
        .chan_en (chan_en_o),
        .trig_en (trig_en_o),
        .sel     (sel_o),
        .sw_trig (sw_trig_o),
        .hw_rise (hw_rise),
        .dout    (dout)
    );

    // R2: in direct mode, a write reaches the output on the following edge.
    a_r2_direct_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && chan_en_o && !trig_en_o && !ctrl_wr) |=> ##1 (dout == $past(data_in, 2)));
endmodule

// File: tb/dac_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module dac_xfer_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_wr = 1'b0;
    logic [11:0] data_in = '0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_chan_en = 1'b0;
    logic        ctrl_trig_en = 1'b0;
    logic [3:0]  ctrl_sel = '0;
    logic        sw_trig_wr = 1'b0;
    logic [15:0] hw_trig = '0;
    logic        chan_en_o, trig_en_o, sw_trig_o;
    logic [3:0]  sel_o;
    logic [11:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    dac_xfer_ctrl u_dac_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .ctrl_wr(ctrl_wr), .ctrl_chan_en(ctrl_chan_en), .ctrl_trig_en(ctrl_trig_en),
        .ctrl_sel(ctrl_sel), .sw_trig_wr(sw_trig_wr), .hw_trig(hw_trig),
        .chan_en_o(chan_en_o), .trig_en_o(trig_en_o), .sel_o(sel_o),
        .sw_trig_o(sw_trig_o), .dout(dout)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Advance n rising edges and stop at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic ce, input logic te, input logic [3:0] s);
        ctrl_wr = 1'b1; ctrl_chan_en = ce; ctrl_trig_en = te; ctrl_sel = s;
        step(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [11:0] d);
        data_wr = 1'b1; data_in = d;
        step(1);
        data_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 dout", dout, 0);
        chk("R1 sw bit", sw_trig_o, 0);
        chk("R1 enables", {chan_en_o, trig_en_o}, 0);
        chk("R1 select", sel_o, 0);
    endtask

    task automatic t_direct;
        wr_ctrl(1'b1, 1'b0, 4'd0);
        wr_data(12'hFFF);
        chk("R2 not yet copied", dout, 12'h000);
        step(1);
        chk("R2 copy 0xFFF", dout, 12'hFFF);
        wr_data(12'h000);
        step(1);
        chk("R2 copy 0x000", dout, 12'h000);
        wr_data(12'hA5C);
        step(1);
        chk("R2 copy 0xA5C", dout, 12'hA5C);
    endtask

    task automatic t_hw_edge;
        wr_ctrl(1'b0, 1'b1, 4'd3);
        wr_ctrl(1'b1, 1'b1, 4'd3);
        wr_data(12'h123);
        step(3);
        chk("R2 no copy with trigger on", dout, 12'hA5C);
        hw_trig[3] = 1'b1;
        step(2);
        chk("R3 before third edge", dout, 12'hA5C);
        step(1);
        chk("R3 at third edge", dout, 12'h123);
    endtask

    task automatic t_level;
        wr_data(12'h456);
        step(5);
        chk("R4 level high", dout, 12'h123);
        hw_trig[3] = 1'b0;
        step(5);
        chk("R4 falling edge", dout, 12'h123);
    endtask

    task automatic t_other_lines;
        hw_trig[5] = 1'b1; hw_trig[0] = 1'b1; hw_trig[15] = 1'b1;
        step(6);
        chk("R5 unselected lines", dout, 12'h123);
        hw_trig = '0;
        step(4);
    endtask

    task automatic t_pending;
        hw_trig[3] = 1'b1;
        @(posedge clk); @(negedge clk);
        data_wr = 1'b1; data_in = 12'h789;
        @(posedge clk); @(negedge clk);
        data_wr = 1'b0;
        chk("R9 still pending", dout, 12'h123);
        step(1);
        chk("R9 completion value", dout, 12'h789);
        hw_trig[3] = 1'b0;
        step(4);
    endtask

    task automatic t_lock;
        wr_ctrl(1'b1, 1'b1, 4'd5);
        chk("R7 locked select", sel_o, 3);
        wr_ctrl(1'b0, 1'b1, 4'd5);
        chk("R7 disabling write still locked", sel_o, 3);
        chk("R7 channel now off", chan_en_o, 0);
        wr_ctrl(1'b0, 1'b1, 4'd5);
        chk("R7 unlocked select", sel_o, 5);
    endtask

    task automatic t_disabled;
        hw_trig[5] = 1'b1;
        step(6);
        chk("R8 hw edge while off", dout, 12'h789);
        hw_trig[5] = 1'b0;
        wr_ctrl(1'b0, 1'b0, 4'd5);
        wr_data(12'h321);
        step(3);
        chk("R8 direct write while off", dout, 12'h789);
        wr_ctrl(1'b0, 1'b1, 4'd0);
        sw_trig_wr = 1'b1;
        step(1);
        sw_trig_wr = 1'b0;
        chk("R8 sw bit while off", sw_trig_o, 0);
        step(2);
        chk("R8 sw write while off", dout, 12'h789);
    endtask

    task automatic t_sw;
        wr_ctrl(1'b1, 1'b1, 4'd0);
        sw_trig_wr = 1'b1;
        step(1);
        sw_trig_wr = 1'b0;
        chk("R6 bit set", sw_trig_o, 1);
        chk("R6 not loaded yet", dout, 12'h789);
        step(1);
        chk("R6 bit cleared", sw_trig_o, 0);
        chk("R6 loaded", dout, 12'h321);
        wr_data(12'h654);
        hw_trig[0] = 1'b1;
        step(6);
        chk("R5 line 0 in sw mode", dout, 12'h321);
        hw_trig[0] = 1'b0;
        sw_trig_wr = 1'b1;
        step(1);
        sw_trig_wr = 1'b0;
        step(1);
        chk("R6 second sw load", dout, 12'h654);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_direct();
        t_hw_edge();
        t_level();
        t_other_lines();
        t_pending();
        t_lock();
        t_disabled();
        t_sw();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule